// File: doc/BRIEF.md
# Configuration Packet Stream Processor

This block takes in a stream of 32-bit configuration words over a valid/ready handshake. It ignores everything until a synchronization word arrives. Once synchronized, it reads each word as a packet header and carries out register reads and writes on a small internal bank of configuration registers. A Type 1 header names a register and gives a short word count. A Type 2 header gives a long word count and acts on the register named by the last Type 1 header. Read results leave on a separate 32-bit output stream, which has its own valid/ready handshake.

A frame-readback register returns words from an internal pattern memory. The start index is the frame address register. A write of the desynchronize code to the command register sends the block back to its unsynchronized state. An upstream controller normally sends filler and bus-width words, then the sync word, then header/payload packets, and ends with a desynchronize command.

Top module: `cfg_pkt_engine`

## Requirements
- R1: After reset, `synced`, `out_valid` and `hdr_err` are 0 and `in_ready` is 1.
- R2: While unsynchronized, every input word is accepted and has no effect. This includes 0xFFFFFFFF, 0x000000BB, 0x11220044 and valid headers. The word 0xAA995566 sets `synced` from the next cycle.
- R3: A header with bits [31:29]=001 is Type 1: opcode in [28:27], register address in [26:13], word count in [10:0]. Opcode 0 is no-op, 1 is read and 2 is write. 0x20000000 is consumed with no effect.
- R4: Registers 0 (CRC), 1 (frame address), 4 (command), 5 (control) and 6 (mask) are writable. A write of N words leaves the last word stored. A read of N words returns the current value N times.
- R5: Register 7 (status) reads {30'b0, hdr_err, 1'b1}. Register 12 reads parameter ID_VALUE and register 22 reads parameter BOOT_VALUE. Writes to these three registers are ignored.
- R6: All other addresses read as zero and ignore writes. This includes 2, the frame-input register, whose payload is discarded.
- R7: A read of register 3 returns N words. Word k is P((F+k) mod FRAME_DEPTH), where F is the frame address register and P(i) = {~i[15:0], i[15:0]}.
- R8: A header with bits [31:29]=010 is Type 2, with opcode in [28:27] and word count in [26:0]. It acts on the address of the most recent Type 1 header. This lets a Type 1 read or write with count 0 followed by a Type 2 header move long bursts.
- R9: Writing 0x0000000D to register 4 clears `synced` after that word. Later words are ignored until the next sync word. Other command codes (0x04, 0x05, 0x07, 0x0B) are stored and read back.
- R10: From the cycle after a read header with nonzero count is accepted, `in_ready` stays 0 until the last read word is accepted. While `out_valid` is high and `out_ready` is low, `out_data` holds.
- R11: While synchronized, a header whose type is neither 001 nor 010 sets `hdr_err`, which stays set until reset. The header is otherwise skipped. A synchronized 0xFFFFFFFF is dropped without setting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input configuration word |
| in_ready | output | 1 | Block accepts an input word |
| out_valid | output | 1 | Readback word valid |
| out_data | output | 32 | Readback word |
| out_ready | input | 1 | Downstream accepts the readback word |
| synced | output | 1 | Block is synchronized |
| hdr_err | output | 1 | Sticky unknown-header flag |

## Verification
A wrong sync state shows at once on `synced`. It also shows as readbacks that appear or go missing right after a header. A wrong remembered address or word count surfaces only at the next Type 2 packet, as data from the wrong register or a burst of the wrong length; that is why the bench reads every write back. Faults in the frame pointer show in the first and the wrapping word of a frame readback. Handshake faults show as `in_ready` rising during a burst or `out_data` changing under backpressure.

// File: rtl/cfg_pkt_pkg.sv
package cfg_pkt_pkg;
  localparam logic [31:0] SYNC_WORD  = 32'hAA99_5566;
  localparam logic [31:0] FILL_WORD  = 32'hFFFF_FFFF;
  localparam logic [31:0] CMD_DESYNC = 32'h0000_000D;

  localparam int ADDR_W = 14;
  localparam int CNT_W  = 27;

  localparam logic [ADDR_W-1:0] A_CRC   = 14'd0;
  localparam logic [ADDR_W-1:0] A_FADDR = 14'd1;
  localparam logic [ADDR_W-1:0] A_FIN   = 14'd2;
  localparam logic [ADDR_W-1:0] A_FOUT  = 14'd3;
  localparam logic [ADDR_W-1:0] A_CMD   = 14'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 14'd5;
  localparam logic [ADDR_W-1:0] A_MASK  = 14'd6;
  localparam logic [ADDR_W-1:0] A_STAT  = 14'd7;
  localparam logic [ADDR_W-1:0] A_ID    = 14'd12;
  localparam logic [ADDR_W-1:0] A_BOOT  = 14'd22;

  typedef enum logic [1:0] {OP_NOP = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2, OP_RSV = 2'd3} op_e;
  typedef enum logic [1:0] {HK_SHORT, HK_LONG, HK_BAD} hdr_kind_e;
  typedef enum logic [1:0] {ST_UNSYNC, ST_HDR, ST_WR, ST_RD} eng_state_e;

  typedef struct packed {
    hdr_kind_e         kind;
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [CNT_W-1:0]  count;
  } hdr_t;
endpackage

// File: rtl/cfg_hdr_decode.sv
module cfg_hdr_decode
  import cfg_pkt_pkg::*;
(
  input  logic [31:0] word,
  output hdr_t        hdr
);
  always_comb begin
    hdr.op   = op_e'(word[28:27]);
    hdr.addr = word[26:13];
    case (word[31:29])
      3'b001: begin
        hdr.kind  = HK_SHORT;
        hdr.count = {{(CNT_W-11){1'b0}}, word[10:0]};
      end
      3'b010: begin
        hdr.kind  = HK_LONG;
        hdr.count = word[26:0];
      end
      default: begin
        hdr.kind  = HK_BAD;
        hdr.count = '0;
      end
    endcase
  end
endmodule

// File: rtl/cfg_frame_rom.sv
module cfg_frame_rom #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0] addr,
  output logic [31:0]   data
);
  logic [31:0] pat_mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_pat
    localparam logic [15:0] IDX = 16'(g);
    assign pat_mem[g] = {~IDX, IDX};
  end

  assign data = pat_mem[addr];
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_pkt_pkg::*;
#(
  parameter logic [31:0] ID_VALUE   = 32'h1A2B_3C4D,
  parameter logic [31:0] BOOT_VALUE = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              err_flag,
  output logic [31:0]       rdata,
  output logic [31:0]       far_q
);
  logic [31:0] crc_q, cmd_q, ctrl_q, mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q  <= '0;
      far_q  <= '0;
      cmd_q  <= '0;
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CRC:   crc_q  <= wdata;
        A_FADDR: far_q  <= wdata;
        A_CMD:   cmd_q  <= wdata;
        A_CTRL:  ctrl_q <= wdata;
        A_MASK:  mask_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_CRC:   rdata = crc_q;
      A_FADDR: rdata = far_q;
      A_CMD:   rdata = cmd_q;
      A_CTRL:  rdata = ctrl_q;
      A_MASK:  rdata = mask_q;
      A_STAT:  rdata = {30'd0, err_flag, 1'b1};
      A_ID:    rdata = ID_VALUE;
      A_BOOT:  rdata = BOOT_VALUE;
      default: rdata = '0;
    endcase
  end

  // R4: the frame address register changes only through a write to it
  assert_far_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_FADDR) |=> $stable(far_q));
endmodule

// File: rtl/cfg_pkt_engine.sv
module cfg_pkt_engine
  import cfg_pkt_pkg::*;
#(
  parameter int          FRAME_DEPTH = 256,
  parameter logic [31:0] ID_VALUE    = 32'h1A2B_3C4D,
  parameter logic [31:0] BOOT_VALUE  = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  output logic        in_ready,
  output logic        out_valid,
  output logic [31:0] out_data,
  input  logic        out_ready,
  output logic        synced,
  output logic        hdr_err
);
  localparam int FAW = $clog2(FRAME_DEPTH);

  eng_state_e        state;
  hdr_t              hdr;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  wr_cnt, rd_cnt;
  logic [FAW-1:0]    rd_ptr;
  logic [31:0]       bank_rdata, far_q, frame_word, rd_word;
  logic              accept, wr_en, desync, out_free;

  assign in_ready = (state != ST_RD);
  assign accept   = in_valid && in_ready;
  assign synced   = (state != ST_UNSYNC);
  assign wr_en    = (state == ST_WR) && accept;
  assign desync   = wr_en && (cur_addr == A_CMD) && (in_data == CMD_DESYNC);
  assign out_free = !out_valid || out_ready;
  assign rd_word  = (cur_addr == A_FOUT) ? frame_word : bank_rdata;

  cfg_hdr_decode u_dec (.word(in_data), .hdr(hdr));

  cfg_reg_bank #(.ID_VALUE(ID_VALUE), .BOOT_VALUE(BOOT_VALUE)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(cur_addr), .wdata(in_data),
    .err_flag(hdr_err), .rdata(bank_rdata), .far_q(far_q)
  );

  cfg_frame_rom #(.DEPTH(FRAME_DEPTH), .AW(FAW)) u_rom (.addr(rd_ptr), .data(frame_word));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_UNSYNC;
      cur_addr  <= '0;
      wr_cnt    <= '0;
      rd_cnt    <= '0;
      rd_ptr    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      hdr_err   <= 1'b0;
    end else begin
      case (state)
        ST_UNSYNC: if (accept && in_data == SYNC_WORD) state <= ST_HDR;
        ST_HDR: if (accept && in_data != FILL_WORD) begin
          if (hdr.kind == HK_BAD) begin
            hdr_err <= 1'b1;
          end else begin
            if (hdr.kind == HK_SHORT) cur_addr <= hdr.addr;
            if (hdr.op == OP_RD && hdr.count != '0) begin
              rd_cnt <= hdr.count;
              rd_ptr <= far_q[FAW-1:0];
              state  <= ST_RD;
            end else if (hdr.op == OP_WR && hdr.count != '0) begin
              wr_cnt <= hdr.count;
              state  <= ST_WR;
            end
          end
        end
        ST_WR: if (accept) begin
          wr_cnt <= wr_cnt - 1'b1;
          if (desync) state <= ST_UNSYNC;
          else if (wr_cnt == 1) state <= ST_HDR;
        end
        ST_RD: if (out_free) begin
          if (rd_cnt != '0) begin
            out_valid <= 1'b1;
            out_data  <= rd_word;
            rd_cnt    <= rd_cnt - 1'b1;
            rd_ptr    <= rd_ptr + 1'b1;
          end else begin
            out_valid <= 1'b0;
            state     <= ST_HDR;
          end
        end
        default: state <= ST_UNSYNC;
      endcase
    end
  end

  // R10: a stalled readback word holds
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R2: nothing leaves the block while unsynchronized
  assert_quiet_unsync_R2: assert property (@(posedge clk) disable iff (rst)
    !synced |-> !out_valid);
  // R11: error flag is sticky
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    hdr_err |=> hdr_err);
  // R9: desynchronize command drops sync
  assert_desync_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WR && accept && cur_addr == A_CMD && in_data == CMD_DESYNC) |=> !synced);
endmodule

// File: tb/tb_cfg_pkt_engine.sv
module tb_cfg_pkt_engine;
  localparam logic [31:0] ID_V   = 32'h1A2B_3C4D;
  localparam logic [31:0] BOOT_V = 32'h0000_0001;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, synced, hdr_err;
  logic [31:0] out_data;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  cfg_pkt_engine dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .synced(synced), .hdr_err(hdr_err)
  );

  function automatic logic [31:0] t1(input int op, input int addr, input int cnt);
    return (32'h1 << 29) | (32'(op) << 27) | (32'(addr) << 13) | 32'(cnt);
  endfunction
  function automatic logic [31:0] t2(input int op, input int cnt);
    return (32'h2 << 29) | (32'(op) << 27) | 32'(cnt);
  endfunction
  function automatic logic [31:0] pat(input int i);
    logic [15:0] v;
    v = 16'(i);
    return {~v, v};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic get_word(output logic [31:0] w);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    w = out_data;
    out_ready = 1'b1;
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  task automatic read_reg(input int addr, output logic [31:0] w);
    send(t1(1, addr, 1));
    get_word(w);
  endtask

  task automatic quiet(input string req);
    repeat (4) begin
      @(negedge clk);
      chk(req, {30'd0, synced, out_valid}, 32'd0);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset", {28'd0, synced, out_valid, hdr_err, in_ready}, 32'h1);
  endtask

  task automatic t_unsync;
    send(32'hFFFF_FFFF); send(32'h0000_00BB); send(32'h1122_0044);
    send(t1(1, 7, 1));
    quiet("R2 pre-sync words ignored");
    send(32'hAA99_5566);
    @(negedge clk);
    chk("R2 sync word", {31'd0, synced}, 32'h1);
  endtask

  task automatic t_nop_and_fill;
    logic [31:0] w;
    send(32'h2000_0000);
    send(32'hFFFF_FFFF);
    read_reg(7, w);
    chk("R3 nop and R11 filler leave status clean", w, 32'h1);
  endtask

  task automatic t_rw;
    logic [31:0] w;
    send(t1(2, 0, 1)); send(32'h1234_5678);
    send(t1(1, 0, 2));
    repeat (2) begin get_word(w); chk("R4 CRC read repeated", w, 32'h1234_5678); end
    send(t1(2, 6, 2)); send(32'hAAAA_0001); send(32'hBBBB_0002);
    read_reg(6, w);
    chk("R4 last write wins", w, 32'hBBBB_0002);
  endtask

  task automatic t_readonly;
    logic [31:0] w;
    send(t1(2, 12, 1)); send(32'h0);
    send(t1(2, 7, 1));  send(32'hFFFF_0000);
    send(t1(2, 22, 1)); send(32'h5A5A_5A5A);
    read_reg(12, w); chk("R5 ID", w, ID_V);
    read_reg(7, w);  chk("R5 status", w, 32'h1);
    read_reg(22, w); chk("R5 boot", w, BOOT_V);
  endtask

  task automatic t_reserved;
    logic [31:0] w;
    send(t1(2, 9, 1)); send(32'h55);
    read_reg(9, w); chk("R6 reserved reads zero", w, 32'h0);
    send(t1(2, 2, 1)); send(32'h77);
    read_reg(2, w); chk("R6 frame-input reads zero", w, 32'h0);
  endtask

  task automatic t_frame(input int far, input int n);
    logic [31:0] w;
    send(t1(2, 1, 1)); send(32'(far));
    send(t1(1, 3, 0));
    send(t2(1, n));
    for (int k = 0; k < n; k++) begin
      get_word(w);
      chk("R7 R8 frame readback", w, pat((far + k) % 256));
    end
  endtask

  task automatic t_long_write;
    logic [31:0] w;
    send(t1(2, 5, 0));
    send(t2(2, 2)); send(32'hC0C0_0001); send(32'hC0C0_0002);
    read_reg(5, w); chk("R8 long write to control", w, 32'hC0C0_0002);
  endtask

  task automatic t_backpressure;
    logic [31:0] w, first;
    send(t1(1, 0, 3));
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    first = out_data;
    repeat (4) begin
      @(negedge clk);
      chk("R10 stall holds", {30'd0, in_ready, out_valid}, 32'h1);
      chk("R10 data stable", out_data, first);
    end
    repeat (3) begin get_word(w); chk("R10 drained word", w, 32'h1234_5678); end
    @(negedge clk);
    chk("R10 ready back", {31'd0, in_ready}, 32'h1);
  endtask

  task automatic t_cmd;
    logic [31:0] w;
    send(t1(2, 4, 1)); send(32'h7);
    read_reg(4, w); chk("R9 command recorded", w, 32'h7);
    send(t1(2, 4, 1)); send(32'hD);
    @(negedge clk);
    chk("R9 desync", {31'd0, synced}, 32'h0);
    send(t1(1, 7, 1));
    quiet("R9 ignored after desync");
    send(32'hAA99_5566);
    read_reg(4, w); chk("R9 resync", w, 32'hD);
  endtask

  task automatic t_err;
    logic [31:0] w;
    send(32'h6000_0000);
    @(negedge clk);
    chk("R11 error set", {31'd0, hdr_err}, 32'h1);
    read_reg(7, w); chk("R11 status shows error", w, 32'h3);
    send(t1(2, 0, 1)); send(32'h9);
    @(negedge clk);
    chk("R11 error sticky", {31'd0, hdr_err}, 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset;
    t_unsync;
    t_nop_and_fill;
    t_rw;
    t_readonly;
    t_reserved;
    t_frame(16, 4);
    t_frame(254, 4);
    t_long_write;
    t_backpressure;
    t_cmd;
    t_err;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule